// File: doc/BRIEF.md
# Prescaled Compare Timer

This block is an up-counting timer that software drives through a small 32-bit register bus. A 16-bit prescaler divides the input clock. The divided tick steps a counter from zero up to a programmable reload value, and the counter then wraps. When the counter wraps, the block raises an update event. A single compare channel raises a match event when the counter equals a programmed value. Each of the two events sets a sticky status flag. One interrupt line reports the flags whose enables are set.

Software can stop update events on wrap while the counter keeps running freely. It can force an immediate reinitialisation, run the timer once and have it stop itself, and choose whether a new reload value applies at once or only at the next update. A parameter sets the counter width to 16 or 32 bits. Software finds the width by writing all ones to the reload register and reading it back.

Top module: `tmr_compare_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Registers sit at these byte addresses: control 0x00, interrupt enable 0x0C, status 0x10, event 0x14, counter 0x24, prescaler 0x28, reload 0x2C, compare 0x34. Control keeps bits 0 (run), 1 (update disable), 3 (one-shot) and 7 (reload preload). Interrupt enable keeps bits 0 (update) and 1 (compare). Bits not implemented, the event register and unmapped addresses read as zero. A read returns the value in the same cycle.
- R3: Counting starts from zero with prescaler value P and reload value A. The update flag (status bit 0) becomes visible (A+1)(P+1) clock edges after the edge that set run.
- R4: With compare value C, the compare flag (status bit 1) becomes visible C(P+1)+1 edges after the edge that set run. It is set on every edge at which run is high and the counter equals C.
- R5: The reload, counter and compare registers keep only the counter-width low bits. Writing all ones to reload and reading it back gives 2^CNT_W-1. The prescaler keeps 16 bits.
- R6: A counter read returns the live count. A counter write loads the count on its edge and overrides that edge's increment.
- R7: While update disable is set, a wrap sets no update flag. The counter still returns to zero and keeps counting.
- R8: With preload set, a reload write changes only the readback value, and the counting limit takes it at the next update event. With preload clear, the new limit applies at once.
- R9: In one-shot mode the run bit clears itself at the first update event, and the counter then holds at zero.
- R10: Writing 1 to event bit 0 clears the counter and the prescale count, and loads the stored prescaler and reload values. It sets no flag.
- R11: Writing a status bit as 0 clears it and writing it as 1 keeps it. A flag set by hardware on the same edge as a clear stays set.
- R12: `irq` is high exactly when some flag is set together with its enable, and it follows the flags in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Register byte address |
| busWe | input | 1 | Write strobe, takes effect on the rising edge |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for `busAddr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
Every register write lands on the rising edge between two falling edges. Reads are combinational, so the bench samples the result at the falling edge right after that write edge. For timed events the bench counts edges from the edge that set run, k = 0, and reads status at each falling edge. It expects the update flag first at k = (A+1)(P+1) and the compare flag first at k = C(P+1)+1, and it checks these formulas over a sweep of prescaler, reload and compare values. Free-running counts, preload switchover, one-shot stop and the clash between a flag clear and a hardware set are each sampled at one computed k.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Register byte addresses
  localparam logic [7:0] OFF_CTRL   = 8'h00;
  localparam logic [7:0] OFF_IEN    = 8'h0C;
  localparam logic [7:0] OFF_STAT   = 8'h10;
  localparam logic [7:0] OFF_EVT    = 8'h14;
  localparam logic [7:0] OFF_CNT    = 8'h24;
  localparam logic [7:0] OFF_DIV    = 8'h28;
  localparam logic [7:0] OFF_RELOAD = 8'h2C;
  localparam logic [7:0] OFF_CMP    = 8'h34;

  // Control bit positions
  localparam int BIT_RUN     = 0;
  localparam int BIT_NOUPD   = 1;
  localparam int BIT_ONESHOT = 3;
  localparam int BIT_PRELOAD = 7;

  // Status / enable bit positions
  localparam int FLAG_UPD = 0;
  localparam int FLAG_CMP = 1;

  // Strobes and mode levels from control to datapath
  typedef struct packed {
    logic run;
    logic noUpd;
    logic preload;
    logic forceUpd;
    logic loadCount;
    logic loadDiv;
    logic loadReload;
    logic loadCmp;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strobe,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  cntVal,
  output logic [DIV_W-1:0]  divVal,
  output logic [CNT_W-1:0]  reloadVal,
  output logic [CNT_W-1:0]  cmpVal,
  output logic              updEvt,
  output logic              cmpHit
);
  logic [DIV_W-1:0] divShadow, divActive, divCnt;
  logic [CNT_W-1:0] cnt, reloadShadow, reloadActive, cmpReg;
  logic             tick, wrapNow;
  logic             wdataUnused;

  assign wdataUnused = ^wdata;

  assign tick    = strobe.run && (divCnt == divActive);
  assign wrapNow = tick && (cnt == reloadActive);
  assign updEvt  = wrapNow && !strobe.noUpd;
  assign cmpHit  = strobe.run && (cnt == cmpReg);

  // Prescale counter
  always_ff @(posedge clk) begin
    if (!rstN)                divCnt <= '0;
    else if (strobe.forceUpd) divCnt <= '0;
    else if (strobe.run)      divCnt <= tick ? '0 : divCnt + DIV_W'(1);
  end

  // Main counter
  always_ff @(posedge clk) begin
    if (!rstN)                 cnt <= '0;
    else if (strobe.forceUpd)  cnt <= '0;
    else if (strobe.loadCount) cnt <= wdata[CNT_W-1:0];
    else if (tick)             cnt <= wrapNow ? '0 : cnt + CNT_W'(1);
  end

  // Prescaler stored and active values
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divShadow <= '0;
      divActive <= '0;
    end else begin
      if (strobe.loadDiv) divShadow <= wdata[DIV_W-1:0];
      if (strobe.forceUpd || updEvt) divActive <= divShadow;
    end
  end

  // Reload stored and active values
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadShadow <= '0;
      reloadActive <= '0;
    end else begin
      if (strobe.loadReload) reloadShadow <= wdata[CNT_W-1:0];
      if (strobe.loadReload && !strobe.preload)
        reloadActive <= wdata[CNT_W-1:0];
      else if (strobe.forceUpd || updEvt)
        reloadActive <= reloadShadow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               cmpReg <= '0;
    else if (strobe.loadCmp) cmpReg <= wdata[CNT_W-1:0];
  end

  assign cntVal    = cnt;
  assign divVal    = divShadow;
  assign reloadVal = reloadShadow;
  assign cmpVal    = cmpReg;

  // R10: a forced update leaves both counts at zero
  assert_force_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.forceUpd |=> (cnt == '0 && divCnt == '0));

  // R8: with preload on, the active limit moves only on an update
  assert_preload_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.preload && !strobe.forceUpd && !updEvt) |=> $stable(reloadActive));
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic [DIV_W-1:0]  divVal,
  input  logic [CNT_W-1:0]  reloadVal,
  input  logic [CNT_W-1:0]  cmpVal,
  input  logic              updEvt,
  input  logic              cmpHit,
  output tmrStrobe_t        strobe,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);
  logic runBit, noUpdBit, oneShotBit, preloadBit;
  logic ienUpd, ienCmp, flagUpd, flagCmp;
  logic wrCtrl, wrIen, wrStat, wrEvt, wrCnt, wrDiv, wrReload, wrCmp;
  logic [DATA_W-1:0] cntWide, reloadWide, cmpWide;
  logic wdataUnused;

  assign wdataUnused = ^busWdata;

  assign wrCtrl   = busWe && (busAddr == ADDR_W'(OFF_CTRL));
  assign wrIen    = busWe && (busAddr == ADDR_W'(OFF_IEN));
  assign wrStat   = busWe && (busAddr == ADDR_W'(OFF_STAT));
  assign wrEvt    = busWe && (busAddr == ADDR_W'(OFF_EVT));
  assign wrCnt    = busWe && (busAddr == ADDR_W'(OFF_CNT));
  assign wrDiv    = busWe && (busAddr == ADDR_W'(OFF_DIV));
  assign wrReload = busWe && (busAddr == ADDR_W'(OFF_RELOAD));
  assign wrCmp    = busWe && (busAddr == ADDR_W'(OFF_CMP));

  // Control bits; one-shot stop yields to a same-edge software write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runBit     <= 1'b0;
      noUpdBit   <= 1'b0;
      oneShotBit <= 1'b0;
      preloadBit <= 1'b0;
    end else if (wrCtrl) begin
      runBit     <= busWdata[BIT_RUN];
      noUpdBit   <= busWdata[BIT_NOUPD];
      oneShotBit <= busWdata[BIT_ONESHOT];
      preloadBit <= busWdata[BIT_PRELOAD];
    end else if (oneShotBit && updEvt) begin
      runBit <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ienUpd <= 1'b0;
      ienCmp <= 1'b0;
    end else if (wrIen) begin
      ienUpd <= busWdata[FLAG_UPD];
      ienCmp <= busWdata[FLAG_CMP];
    end
  end

  // Sticky flags: hardware set beats software clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagUpd <= 1'b0;
      flagCmp <= 1'b0;
    end else begin
      flagUpd <= updEvt || (flagUpd && !(wrStat && !busWdata[FLAG_UPD]));
      flagCmp <= cmpHit || (flagCmp && !(wrStat && !busWdata[FLAG_CMP]));
    end
  end

  assign irq = (flagUpd && ienUpd) || (flagCmp && ienCmp);

  always_comb begin
    strobe            = '0;
    strobe.run        = runBit;
    strobe.noUpd      = noUpdBit;
    strobe.preload    = preloadBit;
    strobe.forceUpd   = wrEvt && busWdata[0];
    strobe.loadCount  = wrCnt;
    strobe.loadDiv    = wrDiv;
    strobe.loadReload = wrReload;
    strobe.loadCmp    = wrCmp;
  end

  // Zero-extend counter-width values for readback
  generate
    if (CNT_W < DATA_W) begin : gPad
      assign cntWide    = {{(DATA_W-CNT_W){1'b0}}, cntVal};
      assign reloadWide = {{(DATA_W-CNT_W){1'b0}}, reloadVal};
      assign cmpWide    = {{(DATA_W-CNT_W){1'b0}}, cmpVal};
    end else begin : gFull
      assign cntWide    = cntVal;
      assign reloadWide = reloadVal;
      assign cmpWide    = cmpVal;
    end
  endgenerate

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_W'(OFF_CTRL): begin
        busRdata[BIT_RUN]     = runBit;
        busRdata[BIT_NOUPD]   = noUpdBit;
        busRdata[BIT_ONESHOT] = oneShotBit;
        busRdata[BIT_PRELOAD] = preloadBit;
      end
      ADDR_W'(OFF_IEN): begin
        busRdata[FLAG_UPD] = ienUpd;
        busRdata[FLAG_CMP] = ienCmp;
      end
      ADDR_W'(OFF_STAT): begin
        busRdata[FLAG_UPD] = flagUpd;
        busRdata[FLAG_CMP] = flagCmp;
      end
      ADDR_W'(OFF_CNT):    busRdata = cntWide;
      ADDR_W'(OFF_DIV):    busRdata = DATA_W'(divVal);
      ADDR_W'(OFF_RELOAD): busRdata = reloadWide;
      ADDR_W'(OFF_CMP):    busRdata = cmpWide;
      default:             busRdata = '0;
    endcase
  end

  // R11: a flag persists until a status write
  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    (flagUpd && !wrStat) |=> flagUpd);

  // R7: with update disable, the update flag cannot appear
  assert_noupd_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (noUpdBit && !flagUpd) |=> !flagUpd);

  // R9: one-shot stops the counter at the update event
  assert_oneshot_stop_R9: assert property (@(posedge clk) disable iff (!rstN)
    (oneShotBit && updEvt && !wrCtrl) |=> !runBit);
endmodule

// File: rtl/tmr_compare_timer.sv
module tmr_compare_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);
  tmrStrobe_t       strobe;
  logic [CNT_W-1:0] cntVal, reloadVal, cmpVal;
  logic [DIV_W-1:0] divVal;
  logic             updEvt, cmpHit;

  tmr_ctrl #(.CNT_W(CNT_W), .DIV_W(DIV_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .cntVal(cntVal), .divVal(divVal), .reloadVal(reloadVal), .cmpVal(cmpVal),
    .updEvt(updEvt), .cmpHit(cmpHit), .strobe(strobe), .busRdata(busRdata), .irq(irq)
  );

  tmr_datapath #(.CNT_W(CNT_W), .DIV_W(DIV_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(busWdata),
    .cntVal(cntVal), .divVal(divVal), .reloadVal(reloadVal), .cmpVal(cmpVal),
    .updEvt(updEvt), .cmpHit(cmpHit)
  );
endmodule

// File: tb/tmr_compare_timer_bench.sv
`timescale 1ns/1ps
module tmr_compare_timer_bench;
  localparam int CNT_W = 16;
  localparam logic [7:0] A_CTRL = 8'h00, A_IEN = 8'h0C, A_STAT = 8'h10, A_EVT = 8'h14;
  localparam logic [7:0] A_CNT = 8'h24, A_DIV = 8'h28, A_RLD = 8'h2C, A_CMP = 8'h34;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  tmr_compare_timer #(.CNT_W(CNT_W)) u_tmr_compare_timer (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a; busWe = 1'b0;
    #1;
    d = busRdata;
  endtask

  // Stop, program, force update, clear flags, then start (start edge is k=0)
  task automatic setup(input int p, input int a, input int c, input logic [31:0] mode);
    wr(A_CTRL, 32'h0);
    wr(A_DIV, 32'(p));
    wr(A_RLD, 32'(a));
    wr(A_CMP, 32'(c));
    wr(A_EVT, 32'h1);
    wr(A_STAT, 32'h0);
    wr(A_IEN, 32'h3);
    wr(A_CTRL, mode | 32'h1);
  endtask

  task automatic sweep(input int p, input int a, input int c);
    logic [31:0] s;
    int kU = -1;
    int kC = -1;
    int lim = (a + 1) * (p + 1) + 2;
    setup(p, a, c, 32'h0);
    for (int k = 1; k <= lim; k++) begin
      @(negedge clk);
      rd(A_STAT, s);
      if (s[0] && kU < 0) kU = k;
      if (s[1] && kC < 0) kC = k;
    end
    check("R3 update delay", 32'(kU), 32'((a + 1) * (p + 1)));
    check("R4 compare delay", 32'(kC), 32'(c * (p + 1) + 1));
    check("R12 irq with both flags", {31'b0, irq}, 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int kU;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    begin
      logic [7:0] addrs [8] = '{A_CTRL, A_IEN, A_STAT, A_EVT, A_CNT, A_DIV, A_RLD, A_CMP};
      for (int i = 0; i < 8; i++) begin
        rd(addrs[i], d);
        check("R1 reset read", d, 32'h0);
      end
    end
    check("R1 reset irq", {31'b0, irq}, 32'h0);

    // R2 register map and readback masks
    wr(A_CTRL, 32'hFFFF_FF8A);
    rd(A_CTRL, d); check("R2 control mask", d, 32'h8A);
    wr(A_CTRL, 32'h0);
    wr(A_IEN, 32'hFF);
    rd(A_IEN, d); check("R2 enable mask", d, 32'h3);
    rd(A_EVT, d); check("R2 event reads zero", d, 32'h0);
    rd(8'h04, d); check("R2 unmapped reads zero", d, 32'h0);
    wr(A_IEN, 32'h0);

    // R5 width discovery and truncation
    wr(A_RLD, 32'hFFFF_FFFF);
    rd(A_RLD, d); check("R5 reload width", d, 32'((64'd1 << CNT_W) - 1));
    wr(A_DIV, 32'h0001_2345);
    rd(A_DIV, d); check("R5 prescaler width", d, 32'h2345);
    wr(A_CMP, 32'hFFFF_FFFF);
    rd(A_CMP, d); check("R5 compare width", d, 32'((64'd1 << CNT_W) - 1));
    wr(A_CNT, 32'hABCD_1234);
    rd(A_CNT, d); check("R5 R6 counter write", d, 32'h1234);

    // R10 forced update clears counter, no flag
    wr(A_EVT, 32'h1);
    rd(A_CNT, d); check("R10 forced clear", d, 32'h0);
    rd(A_STAT, d); check("R10 no flag", d, 32'h0);

    // R3 R4 sweep over prescaler, reload, compare
    for (int p = 0; p < 4; p++)
      for (int a = 1; a < 5; a++)
        for (int c = 0; c <= a; c++)
          sweep(p, a, c);

    // R12 and R11 with both flags set from the last sweep
    wr(A_CTRL, 32'h0);
    wr(A_IEN, 32'h0);
    check("R12 irq masked", {31'b0, irq}, 32'h0);
    wr(A_IEN, 32'h1);
    check("R12 irq update", {31'b0, irq}, 32'h1);
    wr(A_STAT, 32'h2);
    rd(A_STAT, d); check("R11 selective clear", d, 32'h2);
    check("R12 irq after clear", {31'b0, irq}, 32'h0);
    wr(A_IEN, 32'h2);
    check("R12 irq compare", {31'b0, irq}, 32'h1);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); check("R11 full clear", d, 32'h0);
    check("R12 irq none", {31'b0, irq}, 32'h0);

    // R11 hardware set wins over same-edge clear
    setup(3, 100, 0, 32'h0);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); check("R11 set beats clear", d, 32'h2);
    wr(A_CTRL, 32'h0);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); check("R11 clear when idle", d, 32'h0);

    // R6 counter write while running
    setup(0, 32'hFFFF, 32'hFFFF, 32'h0);
    wr(A_CNT, 32'd100);
    rd(A_CNT, d); check("R6 write overrides tick", d, 32'd100);
    @(negedge clk);
    rd(A_CNT, d); check("R6 live count", d, 32'd101);

    // R7 update disable: free-running wrap without flag
    setup(1, 3, 32'hFFFF, 32'h2);
    kU = -1;
    for (int k = 1; k <= 21; k++) begin
      @(negedge clk);
      rd(A_STAT, d);
      if (d[0]) kU = k;
      if (k == 21) begin
        rd(A_CNT, d);
        check("R7 R6 free-run count", d, 32'((21 / 2) % 4));
      end
    end
    check("R7 no update flag", 32'(kU), 32'hFFFF_FFFF);

    // R8 preload on: old limit until update, then new
    wr(A_CTRL, 32'h80);
    wr(A_DIV, 32'h0);
    wr(A_RLD, 32'd3);
    wr(A_CMP, 32'hFFFF);
    wr(A_EVT, 32'h1);
    wr(A_RLD, 32'd9);
    wr(A_STAT, 32'h0);
    wr(A_CTRL, 32'h81);
    kU = -1;
    for (int k = 1; k <= 14; k++) begin
      @(negedge clk);
      rd(A_STAT, d);
      if (d[0] && kU < 0) kU = k;
      if (k == 13) begin rd(A_CNT, d); check("R8 new limit reached", d, 32'd9); end
      if (k == 14) begin rd(A_CNT, d); check("R8 wrap at new limit", d, 32'd0); end
    end
    check("R8 first update on old limit", 32'(kU), 32'd4);
    rd(A_RLD, d); check("R8 readback stored value", d, 32'd9);

    // R8 preload off: new limit at once
    wr(A_CTRL, 32'h0);
    wr(A_RLD, 32'd3);
    wr(A_EVT, 32'h1);
    wr(A_RLD, 32'd6);
    wr(A_STAT, 32'h0);
    wr(A_CTRL, 32'h1);
    kU = -1;
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      rd(A_STAT, d);
      if (d[0] && kU < 0) kU = k;
    end
    check("R8 immediate limit", 32'(kU), 32'd7);

    // R9 one-shot
    setup(0, 2, 32'hFFFF, 32'h8);
    kU = -1;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      rd(A_STAT, d);
      if (d[0] && kU < 0) kU = k;
    end
    check("R9 single update time", 32'(kU), 32'd3);
    rd(A_CTRL, d); check("R9 run cleared", d, 32'h8);
    rd(A_CNT, d); check("R9 counter held", d, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule